// File: doc/BRIEF.md
# Programmable Clock-Enable Divider with Pass-Through

This block turns a free-running clock into a periodic clock-enable strobe. One 32-bit control word sets it up. The upper half holds a 16-bit divisor and the two lowest bits are a run field. When the divisor is at least 2 and both run bits are set, the strobe is high for one cycle in every `divisor` cycles. When the divisor is 0 or 1, the block does not divide: the strobe is high on every cycle, so downstream logic sees the full input rate.

Software can write the whole control word at any time. It can also issue a one-cycle enable command. That command sets both run bits, but only when the divisor that will be in force is 2 or more; otherwise it changes nothing. Writing all zeros stops division and falls back to pass-through. Every write reloads the period counter, so the first strobe after a write comes a full period later. There is no data stream, so all pins are plain control and status signals.

Top module: `clkdiv16_top`

## Requirements
- R1: After reset the control word reads 0x0000_0000. The divisor is read back in bits 31:16 and the run field in bits 1:0.
- R2: While the divisor is 0 or 1, `tick_o` and `bypass_o` are high on every cycle, whatever the run field holds.
- R3: An enable command with a divisor of 2 or more sets bits 1:0 to 2'b11 and leaves the divisor unchanged.
- R4: An enable command while the divisor is 0 or 1 leaves the control word unchanged.
- R5: While the divisor is 2 or more and bits 1:0 are not 2'b11, `tick_o` stays low.
- R6: Writing 0x0000_0000 makes the word read zero and returns the output to pass-through.
- R7: With divisor D ≥ 2 and run field 2'b11, `tick_o` is high for exactly one cycle in every D. The first strobe is in the D-th cycle after the write edge.
- R8: Every write restarts the period, so the next strobe comes D cycles after that write edge.
- R9: Bits 15:2 always read as zero, and write data in those bits has no effect.
- R10: A write and an enable command in the same cycle apply the enable rule to the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write the control word this cycle |
| wr_data | input | 32 | Value to write |
| en_cmd | input | 1 | Enable command (sets the run field if the divisor is 2 or more) |
| rd_data | output | 32 | Current control word |
| tick_o | output | 1 | Clock-enable strobe |
| bypass_o | output | 1 | High while the divisor is below 2 |

## Verification
A register write and an enable command can land in the same cycle. In that case the enable rule must be judged against the divisor being written, not the old one. The bench drives both together in two cases. One writes divisor 6 with the run field clear, and the word must read back with the run field set. The other writes divisor 1 with only one run bit set, and the word must read back exactly as written. In each case it also counts strobes over a fixed window to confirm that the counter restarted from the write edge.

// File: rtl/clkdiv16_pkg.sv
package clkdiv16_pkg;
  localparam int RUN_W = 2;
  localparam logic [RUN_W-1:0] RUN_ON = 2'b11;
endpackage

// File: rtl/clkdiv16_regs.sv
module clkdiv16_regs
  import clkdiv16_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2*DIV_W-1:0] wr_data,
  input  logic               en_cmd,
  output logic [DIV_W-1:0]   div_o,
  output logic [RUN_W-1:0]   run_o
);
  localparam int REG_W = 2 * DIV_W;

  logic [DIV_W-1:0] div_q, div_nxt;
  logic [RUN_W-1:0] run_q, run_nxt;

  // Merge write and enable command; enable judges the value in force next.
  always_comb begin
    div_nxt = wr_en ? wr_data[REG_W-1:DIV_W] : div_q;
    run_nxt = wr_en ? wr_data[RUN_W-1:0] : run_q;
    if (en_cmd && (div_nxt >= DIV_W'(2)))
      run_nxt = RUN_ON;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      run_q <= '0;
    end else begin
      div_q <= div_nxt;
      run_q <= run_nxt;
    end
  end

  assign div_o = div_q;
  assign run_o = run_q;

  // R3: enable command sets run field, keeps divisor
  p_enable_sets_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cmd && !wr_en && div_q >= DIV_W'(2)) |=> (run_q == RUN_ON && $stable(div_q)));

  // R4: enable command below 2 is a no-op
  p_enable_noop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cmd && !wr_en && div_q < DIV_W'(2)) |=> ($stable(div_q) && $stable(run_q)));

  // R10: combined write and enable with a large divisor
  p_wr_en_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_cmd && wr_en && wr_data[REG_W-1:DIV_W] >= DIV_W'(2)) |=> (run_q == RUN_ON));
endmodule

// File: rtl/clkdiv16_counter.sv
module clkdiv16_counter
  import clkdiv16_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic [RUN_W-1:0] run_i,
  input  logic             reload_i,
  output logic             tick_o,
  output logic             bypass_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             pass;
  logic             active;
  logic             at_end;

  assign pass   = (div_i < DIV_W'(2));
  assign active = !pass && (run_i == RUN_ON);
  assign at_end = (cnt_q == div_i - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (reload_i || !active || at_end)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + DIV_W'(1);
  end

  assign tick_o   = pass || (active && at_end);
  assign bypass_o = pass;

  // R7: counter never runs past the divisor while dividing
  p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < div_i));

  // R8: the cycle right after a write never carries a divided strobe
  p_reload_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (bypass_o || !tick_o));
endmodule

// File: rtl/clkdiv16_top.sv
module clkdiv16_top
  import clkdiv16_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2*DIV_W-1:0] wr_data,
  input  logic               en_cmd,
  output logic [2*DIV_W-1:0] rd_data,
  output logic               tick_o,
  output logic               bypass_o
);
  localparam int REG_W = 2 * DIV_W;
  localparam int GAP_W = DIV_W - RUN_W;

  logic [DIV_W-1:0] div_w;
  logic [RUN_W-1:0] run_w;

  clkdiv16_regs #(.DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .en_cmd(en_cmd), .div_o(div_w), .run_o(run_w)
  );

  clkdiv16_counter #(.DIV_W(DIV_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .div_i(div_w), .run_i(run_w),
    .reload_i(wr_en), .tick_o(tick_o), .bypass_o(bypass_o)
  );

  assign rd_data = {div_w, {GAP_W{1'b0}}, run_w};

  // R2: pass-through strobes every cycle
  p_bypass_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[REG_W-1:DIV_W] < DIV_W'(2)) |-> (tick_o && bypass_o));

  // R5: idle divider holds strobe low
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[REG_W-1:DIV_W] >= DIV_W'(2) && rd_data[RUN_W-1:0] != RUN_ON) |-> !tick_o);

  // R6: a zero write returns to pass-through
  p_zero_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !en_cmd && wr_data == '0) |=> (rd_data == '0 && tick_o));

  // R9: reserved bits read zero
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DIV_W-1:RUN_W] == '0);
endmodule

// File: tb/clkdiv16_tb_top.sv
`timescale 1ns/1ps
module clkdiv16_tb_top;
  localparam int WIN = 60;
  localparam int NV  = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        en_cmd = 1'b0;
  logic [31:0] rd_data;
  logic        tick_o;
  logic        bypass_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clkdiv16_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .en_cmd(en_cmd), .rd_data(rd_data), .tick_o(tick_o), .bypass_o(bypass_o)
  );

  // {write data, enable with write, expected read, expected ticks in WIN}
  typedef struct packed {
    logic [31:0] wdata;
    logic        en;
    logic [31:0] rexp;
    logic [7:0]  ticks;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h0004_0003, 1'b0, 32'h0004_0003, 8'd15}, // R7
    '{32'h0005_0003, 1'b0, 32'h0005_0003, 8'd12}, // R7
    '{32'h0003_FFFF, 1'b0, 32'h0003_0003, 8'd20}, // R9
    '{32'h0001_0000, 1'b0, 32'h0001_0000, 8'd60}, // R2
    '{32'h0000_0003, 1'b0, 32'h0000_0003, 8'd60}, // R2
    '{32'h0007_0001, 1'b0, 32'h0007_0001, 8'd0},  // R5
    '{32'h0006_0000, 1'b1, 32'h0006_0003, 8'd10}, // R10
    '{32'h0001_0002, 1'b1, 32'h0001_0002, 8'd60}, // R10 R4
    '{32'hFFFF_0003, 1'b0, 32'hFFFF_0003, 8'd0},  // R7
    '{32'h0002_0003, 1'b0, 32'h0002_0003, 8'd30}, // R7
    '{32'h0000_0000, 1'b0, 32'h0000_0000, 8'd60}  // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge; returns at the negedge right after the write edge.
  task automatic drive(input logic w, input logic [31:0] d, input logic e);
    @(negedge clk);
    wr_en = w; wr_data = d; en_cmd = e;
    @(negedge clk);
    wr_en = 1'b0; en_cmd = 1'b0;
  endtask

  task automatic count_ticks(output int n);
    n = 0;
    for (int k = 0; k < WIN; k++) begin
      if (tick_o) n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    int first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R2 pass-through at reset
    check("R1", rd_data, 32'h0);
    check("R2", {31'b0, tick_o & bypass_o}, 32'h1);

    foreach (VECS[i]) begin
      drive(1'b1, VECS[i].wdata, VECS[i].en);
      check($sformatf("vec%0d rd", i), rd_data, VECS[i].rexp);
      count_ticks(n);
      check($sformatf("vec%0d ticks", i), n, {24'b0, VECS[i].ticks});
    end

    // R5 then R3: enable command alone after an idle setup
    drive(1'b1, 32'h0008_0000, 1'b0);
    count_ticks(n);
    check("R5", n, 0);
    drive(1'b0, 32'h0, 1'b1);
    check("R3", rd_data, 32'h0008_0003);
    count_ticks(n);
    check("R3 ticks", n, 7);

    // R4: enable command alone with divisor 1
    drive(1'b1, 32'h0001_0001, 1'b0);
    drive(1'b0, 32'h0, 1'b1);
    check("R4", rd_data, 32'h0001_0001);

    // R7 exact first-strobe cycle with divisor 5
    drive(1'b1, 32'h0005_0003, 1'b0);
    first = -1;
    for (int k = 0; k < 10; k++) begin
      if (tick_o && first < 0) first = k;
      @(negedge clk);
    end
    check("R7 first", first, 4);

    // R8: rewrite mid-period restarts the count
    drive(1'b1, 32'h0004_0003, 1'b0);
    @(negedge clk);
    drive(1'b1, 32'h0004_0003, 1'b0);
    first = -1;
    for (int k = 0; k < 8; k++) begin
      if (tick_o && first < 0) first = k;
      @(negedge clk);
    end
    check("R8", first, 3);

    // R6: zero write after dividing
    drive(1'b1, 32'h0, 1'b0);
    check("R6", {rd_data[31:1], tick_o}, 32'h1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule